// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Supervisor

This block sits between the protection comparators of a three-phase gate driver and its six output stages. It watches a synchronous overcurrent flag and a synchronous low-side supply undervoltage flag. From them it produces a per-gate shutdown request and an active-low fault indication. An enable input can also force the gates off without reporting a fault.

An overcurrent flag must stay high for a programmable number of clock cycles before it counts as a trip, so short noise pulses are rejected. A qualified trip latches the fault. The latch is released only after a programmable clear delay, and that delay is counted by a timer that is held at zero for as long as the trip lasts. The timer stands in for an RC network that is discharged on a trip and recharges once the overcurrent condition has gone. An undervoltage condition bypasses both the latch and the timer: it drives the fault and the shutdown for exactly as long as the flag is high.

Top module: `ocp_fault_sup`

## Requirements
- R1: An overcurrent flag that is high for fewer than FILT_CYC consecutive clock cycles has no effect on fault_n or gate_off. This holds while idle and while the clear timer is running, and a rejected pulse does not move the release time.
- R2: An overcurrent flag sampled high on FILT_CYC consecutive rising edges drives fault_n low and every gate_off bit high on the next edge after the last of them (edge FILT_CYC+1, counting the first high sample as edge 1).
- R3: While a qualified trip persists the clear timer stays at zero, so the fault stays asserted however long the overcurrent lasts.
- R4: Let edge F be the first edge that samples the overcurrent flag low after a qualified trip. The fault and shutdown remain asserted through edge F+CLR_CYC and are released at edge F+CLR_CYC+1.
- R5: A new qualified trip during the clear countdown keeps the fault latched and restarts the countdown from zero when that trip ends.
- R6: uv_flag high drives fault_n low and all gate_off bits high in the same cycle, combinationally. When the flag falls they are released in the same cycle, with no delay timer.
- R7: fault_n is low exactly when the undervoltage flag is high or the overcurrent latch is set. Either cause alone keeps the fault asserted while the other clears.
- R8: drv_en low sets all gate_off bits high and leaves fault_n high when no fault cause is present.
- R9: Asserting rst_n low clears the latch at once and saturates the timer. After reset the block is in the non-faulted state (fault_n high, gate_off all zero with drv_en high) and needs no clear delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oc_flag | input | 1 | Overcurrent comparator flag, active high, synchronous |
| uv_flag | input | 1 | Low-side supply undervoltage flag, active high, synchronous |
| drv_en | input | 1 | Driver enable, active high; low forces all gates off |
| fault_n | output | 1 | Fault indication, active low |
| gate_off | output | NUM_GATES | Per-gate shutdown request, active high |

## Verification
A trip filter whose count is off by one shows up at the ports as a fault that starts one edge early or late, or as a glitch of FILT_CYC-1 cycles that gets through. The bench samples on the exact edge and on its neighbour, so this is caught at once. A clear timer that runs during the trip, or that is not reset by a retrigger, shows up as an early release, visible CLR_CYC edges after the trip begins or after the retrigger. Undervoltage and enable paths are combinational, so a wrong gate_off or fault_n shows in the same cycle as the flag change. A latch that survives reset is seen on the first sample after reset.

// File: rtl/ocp_fault_pkg.sv
package ocp_fault_pkg;

  // Overcurrent latch states
  typedef enum logic [1:0] {
    LATCH_CLEAR   = 2'd0,  // no overcurrent fault held
    LATCH_TRIPPED = 2'd1,  // qualified trip present, timer held at zero
    LATCH_RECOVER = 2'd2   // trip gone, waiting for the clear delay
  } latch_state_e;

  // Counter width that can hold values 0..max_val (at least one bit)
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ocp_trip_filter.sv
module ocp_trip_filter #(
  parameter int FILT_CYC = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  output logic trip_q
);
  import ocp_fault_pkg::*;

  localparam int FW = cnt_width(FILT_CYC - 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic [FW-1:0] run_q;
  logic [FW-1:0] run_d;
  logic          trip_d;
  logic          run_en;

  always_comb begin
    // count consecutive high samples, saturate at the last one
    run_en = !oc_flag || (run_q != LAST);
    run_d  = oc_flag ? run_q + 1'b1 : '0;
    trip_d = oc_flag && (run_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      trip_q <= trip_d;
    end
  end

endmodule

// File: rtl/ocp_clear_timer.sv
module ocp_clear_timer #(
  parameter int CLR_CYC = 190000,
  parameter int TW      = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_q,
  output logic [TW-1:0] tmr_q
);

  localparam logic [TW-1:0] TOP = TW'(CLR_CYC);

  logic [TW-1:0] tmr_d;
  logic          tmr_en;

  always_comb begin
    // trip holds the count at zero (capacitor discharged); otherwise
    // count up until saturated at the threshold
    tmr_en = trip_q || (tmr_q != TOP);
    tmr_d  = trip_q ? '0 : tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= TOP;
    else if (tmr_en) tmr_q <= tmr_d;
  end

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch #(
  parameter int CLR_CYC = 190000,
  parameter int TW      = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_q,
  input  logic [TW-1:0] tmr_q,
  output logic          latch_q
);
  import ocp_fault_pkg::*;

  localparam logic [TW-1:0] TOP = TW'(CLR_CYC);

  latch_state_e st_q;
  latch_state_e st_d;
  logic         tmr_done;

  always_comb begin
    tmr_done = (tmr_q == TOP);
    st_d     = st_q;
    unique case (st_q)
      LATCH_CLEAR:   if (trip_q) st_d = LATCH_TRIPPED;
      LATCH_TRIPPED: if (!trip_q) st_d = LATCH_RECOVER;
      LATCH_RECOVER: begin
        if (trip_q)        st_d = LATCH_TRIPPED;
        else if (tmr_done) st_d = LATCH_CLEAR;
      end
      default:             st_d = LATCH_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LATCH_CLEAR;
    else        st_q <= st_d;
  end

  assign latch_q = (st_q != LATCH_CLEAR);

endmodule

// File: rtl/ocp_fault_sup.sv
module ocp_fault_sup #(
  parameter int FILT_CYC  = 23,
  parameter int CLR_CYC   = 190000,
  parameter int NUM_GATES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 oc_flag,
  input  logic                 uv_flag,
  input  logic                 drv_en,
  output logic                 fault_n,
  output logic [NUM_GATES-1:0] gate_off
);
  import ocp_fault_pkg::*;

  localparam int TW = cnt_width(CLR_CYC);

  logic          rst_sync_n;
  logic          trip_q;
  logic [TW-1:0] tmr_q;
  logic          latch_q;
  logic          fault_any;

  ocp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ocp_trip_filter #(.FILT_CYC(FILT_CYC)) u_filter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .oc_flag (oc_flag),
    .trip_q  (trip_q)
  );

  ocp_clear_timer #(.CLR_CYC(CLR_CYC), .TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .trip_q (trip_q),
    .tmr_q  (tmr_q)
  );

  ocp_fault_latch #(.CLR_CYC(CLR_CYC), .TW(TW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trip_q  (trip_q),
    .tmr_q   (tmr_q),
    .latch_q (latch_q)
  );

  // undervoltage is not latched; it joins the overcurrent latch here
  assign fault_any = uv_flag | latch_q;
  assign fault_n   = ~fault_any;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    assign gate_off[g] = fault_any | ~drv_en;
  end

endmodule

// File: rtl/ocp_fault_sup_chk.sv
module ocp_fault_sup_chk #(
  parameter int CLR_CYC   = 190000,
  parameter int NUM_GATES = 6,
  parameter int TW        = 18
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 oc_flag,
  input logic                 uv_flag,
  input logic                 drv_en,
  input logic                 fault_n,
  input logic [NUM_GATES-1:0] gate_off,
  input logic                 trip_q,
  input logic [TW-1:0]        tmr_q,
  input logic                 latch_q
);

  // R1: a qualified trip requires the flag on the previous edge
  assert_trip_needs_flag_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trip_q |-> $past(oc_flag));

  // R2: qualified trip sets the latch on the next edge
  assert_trip_sets_latch_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trip_q |=> latch_q);

  // R3: timer held at zero while the trip persists
  assert_timer_held_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trip_q |=> (tmr_q == '0));

  // R4: timer advances by one per cycle once the trip is gone
  assert_timer_counts_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!trip_q && (tmr_q != TW'(CLR_CYC))) |=> (tmr_q == $past(tmr_q) + 1'b1));

  // R4: latch releases only after the timer reached its threshold
  assert_release_at_threshold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(latch_q) |-> ($past(tmr_q) == TW'(CLR_CYC)) && !$past(trip_q));

  // R6: undervoltage drives fault and shutdown at once
  assert_uv_forces_fault_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    uv_flag |-> (!fault_n && (&gate_off)));

  // R7: no fault without a cause
  assert_fault_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fault_n |-> (uv_flag || latch_q));

  // R8: enable low shuts down all gates
  assert_enable_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !drv_en |-> (&gate_off));

endmodule

bind ocp_fault_sup ocp_fault_sup_chk #(
  .CLR_CYC   (CLR_CYC),
  .NUM_GATES (NUM_GATES),
  .TW        (TW)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .oc_flag    (oc_flag),
  .uv_flag    (uv_flag),
  .drv_en     (drv_en),
  .fault_n    (fault_n),
  .gate_off   (gate_off),
  .trip_q     (trip_q),
  .tmr_q      (tmr_q),
  .latch_q    (latch_q)
);

// File: tb/ocp_fault_sup_bench.sv
module ocp_fault_sup_bench;
  localparam int FILT = 4;
  localparam int CLR  = 20;
  localparam int NG   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc = 1'b0;
  logic uv = 1'b0;
  logic en = 1'b1;
  logic fault_n;
  logic [NG-1:0] gate_off;

  always #5 clk = ~clk;

  ocp_fault_sup #(.FILT_CYC(FILT), .CLR_CYC(CLR), .NUM_GATES(NG)) u_ocp_fault_sup (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc), .uv_flag(uv), .drv_en(en),
    .fault_n(fault_n), .gate_off(gate_off)
  );

  typedef struct {
    int    cyc;
    logic  fn;
    logic  sd;
    string req;
  } exp_t;

  exp_t q[$];
  int ncyc = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always @(posedge clk) ncyc <= ncyc + 1;

  // driver side: expectation k edges after the current negedge (k=1 is next)
  task automatic expect_at(input int k, input logic fn, input logic sd, input string req);
    exp_t e;
    int idx;
    e.cyc = ncyc + k; e.fn = fn; e.sd = sd; e.req = req;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > e.cyc) begin idx = i; break; end
    end
    q.insert(idx, e);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    while (q.size() > 0 && q[0].cyc <= ncyc) begin
      exp_t e;
      logic [NG-1:0] sd_exp;
      e = q.pop_front();
      sd_exp = e.sd ? {NG{1'b1}} : {NG{1'b0}};
      checks++;
      if (fault_n !== e.fn || gate_off !== sd_exp) begin
        errors++;
        $display("FAIL %s edge %0d: fault_n=%b gate_off=%b expected fault_n=%b gate_off=%b",
                 e.req, ncyc, fault_n, gate_off, e.fn, sd_exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    // R9: reset state
    expect_at(1, 1'b1, 1'b0, "R9");
    wait_neg(2);

    // R1: glitch of FILT-1 cycles ignored
    oc = 1'b1;
    expect_at(FILT, 1'b1, 1'b0, "R1");
    expect_at(FILT + 2, 1'b1, 1'b0, "R1");
    wait_neg(FILT - 1);
    oc = 1'b0;
    wait_neg(10);

    // R2 / R4: exactly FILT cycles, then release timing
    oc = 1'b1;
    expect_at(FILT, 1'b1, 1'b0, "R2");
    expect_at(FILT + 1, 1'b0, 1'b1, "R2");
    wait_neg(FILT);
    oc = 1'b0;
    expect_at(CLR + 1, 1'b0, 1'b1, "R4");
    expect_at(CLR + 2, 1'b1, 1'b0, "R4");
    wait_neg(CLR + 6);

    // R3: trip longer than the clear delay
    oc = 1'b1;
    expect_at(30, 1'b0, 1'b1, "R3");
    wait_neg(40);
    oc = 1'b0;
    expect_at(CLR + 1, 1'b0, 1'b1, "R3");
    expect_at(CLR + 2, 1'b1, 1'b0, "R3");
    wait_neg(CLR + 6);

    // R5: retrigger during countdown restarts it
    oc = 1'b1;
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(10);
    oc = 1'b1;
    expect_at(CLR - 8, 1'b0, 1'b1, "R5");
    expect_at(CLR + 5, 1'b0, 1'b1, "R5");
    expect_at(CLR + 6, 1'b1, 1'b0, "R5");
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(CLR + 10);

    // R1: short glitch during countdown does not move release
    oc = 1'b1;
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(5);
    oc = 1'b1;
    expect_at(CLR - 4, 1'b0, 1'b1, "R1");
    expect_at(CLR - 3, 1'b1, 1'b0, "R1");
    wait_neg(2);
    oc = 1'b0;
    wait_neg(CLR + 4);

    // R6: undervoltage is immediate and unlatched
    uv = 1'b1;
    expect_at(1, 1'b0, 1'b1, "R6");
    wait_neg(5);
    uv = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R6");
    wait_neg(3);

    // R7: latch keeps fault after uv goes away; uv keeps fault after latch clears
    oc = 1'b1;
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(5);
    uv = 1'b1;
    wait_neg(3);
    uv = 1'b0;
    expect_at(1, 1'b0, 1'b1, "R7");
    expect_at(CLR - 6, 1'b1, 1'b0, "R7");
    wait_neg(CLR);
    oc = 1'b1;
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(5);
    uv = 1'b1;
    expect_at(CLR + 2, 1'b0, 1'b1, "R7");
    wait_neg(CLR + 4);
    uv = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R7");
    wait_neg(3);

    // R8: enable low shuts down without fault
    en = 1'b0;
    expect_at(1, 1'b1, 1'b1, "R8");
    wait_neg(3);
    en = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R8");
    wait_neg(3);

    // R9: reset during a latched fault clears it at once
    oc = 1'b1;
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(3);
    rst_n = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R9");
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    expect_at(1, 1'b1, 1'b0, "R9");
    wait_neg(2);
    // trip works again after reset
    oc = 1'b1;
    expect_at(FILT + 1, 1'b0, 1'b1, "R2");
    wait_neg(FILT);
    oc = 1'b0;
    wait_neg(CLR + 6);

    while (q.size() > 0) @(negedge clk);
    finished = 1'b1;
    report();
  end

endmodule